// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block forms the second operand of an integer ALU, together with the carry bit that a logical operation would pass on to the flags. It reads a 12-bit operand field and has two modes. In the rotated-immediate mode, an 8-bit constant is rotated right by an even amount. In the register mode, a register value is shifted left, shifted right logically or arithmetically, rotated right, or rotated right by one bit through the carry flag. The shift amount comes either from a 5-bit field in the instruction or from the low byte of a second register.

A shift whose amount comes from a register costs one extra cycle. In the first cycle the block raises `stallReq` and latches the low byte of `rsValue`. The pipeline holds the instruction for one more cycle. In that second cycle the block shifts the `rmValue` present then by the latched amount. Rotated-immediate operands and shifts by an instruction-encoded amount complete in the same cycle, through combinational logic, and never stall. The register file read ports and the ALU sit outside this block.

Top module: `operand_shifter`

## Requirements
- R1: When `immSel`=1, `operand` is the zero-extended constant `opField[7:0]` rotated right by twice the value in `opField[11:8]` (0, 2, ... 30 positions).
- R2: In the rotated-immediate mode, `carryOut` equals `operand[31]` when `opField[11:8]` is non-zero, and equals `carryIn` when it is zero.
- R3: In the register mode, `opField[6:5]` selects the shift type (00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right) and `opField[4]`=0 selects an instruction-encoded amount `opField[11:7]`. A left shift by n>0 gives `rmValue<<n` with carry `rmValue[32-n]`. An encoded amount of 0 with type 00 passes `rmValue` through unchanged, with `carryOut`=`carryIn`.
- R4: For encoded amounts, a right logical or right arithmetic shift by n from 1 to 31 gives carry `rmValue[n-1]`. An encoded amount of 0 means a shift by 32: the logical shift gives 0, the arithmetic shift gives 32 copies of `rmValue[31]`, and in both cases the carry is `rmValue[31]`.
- R5: An encoded rotate by n from 1 to 31 gives carry `rmValue[n-1]`. An encoded rotate by 0 is a one-bit rotate through carry: the result is `{carryIn, rmValue[31:1]}` and the carry is `rmValue[0]`.
- R6: When `opField[4]`=1, the shift amount is `rsValue[7:0]` as sampled in the stall cycle. A change of `rsValue` in the following cycle has no effect on the result. An amount of 0 leaves both the value and the carry unchanged.
- R7: For register amounts of 32 or more: a left or right logical shift by exactly 32 gives 0 with carry `rmValue[0]` or `rmValue[31]` respectively, and by more than 32 gives 0 with carry 0. A right arithmetic shift gives all sign bits with carry `rmValue[31]`. A rotate uses the amount modulo 32, and a non-zero multiple of 32 returns `rmValue` unchanged with carry `rmValue[31]`.
- R8: `stallReq` is high for exactly one cycle for each valid register-amount shift, in the first cycle it is presented. It is never high for the rotated-immediate mode, for encoded-amount shifts, or in two consecutive cycles.
- R9: While and after the active-low asynchronous reset `rstN`, the control is idle: `stallReq` stays low with no valid request, and the first register-amount shift after reset stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An instruction occupies the operand stage this cycle |
| immSel | input | 1 | 1 selects the rotated-immediate mode, 0 the register mode |
| opField | input | 12 | Operand field of the instruction |
| rmValue | input | 32 | Value of the register being shifted |
| rsValue | input | 32 | Register holding the shift amount in its low byte |
| carryIn | input | 1 | Current carry flag |
| operand | output | 32 | Second ALU operand |
| carryOut | output | 1 | Shifter carry-out |
| stallReq | output | 1 | One-cycle request to hold the pipeline for a register-amount shift |

## Verification
The assertions check the stall handshake on every cycle: a stall is never requested twice in a row, it is requested only for register-amount shifts, and it is always requested for a fresh one. They also check, on every cycle, the carry rule of the rotated-immediate mode and the pass-through of an unshifted register. The arithmetic of each shift type, the reinterpretation of encoded zero amounts, the handling of register amounts of 32 or more, and the fact that the latched amount wins over a later change of `rsValue` are shown only by the bench scenarios. The bench compares each result with a bit-serial reference model.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

  // Operation chosen by the decoder for the shift core
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shiftKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureAmt;  // latch the register shift amount this cycle
    logic useLatched;  // second cycle: shift by the latched amount
  } shiftCtrl_t;

  // Field positions of the register-mode encoding
  localparam int REG_FLAG_BIT = 4;
  localparam int TYPE_LSB     = 5;
  localparam int SHAMT_LSB    = 7;

endpackage

// File: rtl/opshift_core.sv
module opshift_core
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  shiftKind_e        kind,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [AMT_W-1:0]  amount,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic [IDX_W-1:0] modAmt;
  logic [IDX_W-1:0] lowIdx;
  logic [IDX_W-1:0] highIdx;
  logic             isZero;
  logic             inRange;
  logic             isFull;

  always_comb begin
    modAmt  = amount[IDX_W-1:0];
    lowIdx  = modAmt - IDX_W'(1);
    highIdx = IDX_W'(0) - modAmt;
    isZero  = (amount == '0);
    inRange = (amount < FULL_AMT);
    isFull  = (amount == FULL_AMT);

    result   = srcVal;
    carryOut = carryIn;

    case (kind)
      SK_LSL: begin
        if (!isZero) begin
          if (inRange) begin
            result   = srcVal << modAmt;
            carryOut = srcVal[highIdx];
          end else begin
            result   = '0;
            carryOut = isFull ? srcVal[0] : 1'b0;
          end
        end
      end
      SK_LSR: begin
        if (!isZero) begin
          if (inRange) begin
            result   = srcVal >> modAmt;
            carryOut = srcVal[lowIdx];
          end else begin
            result   = '0;
            carryOut = isFull ? srcVal[DATA_W-1] : 1'b0;
          end
        end
      end
      SK_ASR: begin
        if (!isZero) begin
          if (inRange) begin
            result   = DATA_W'($signed(srcVal) >>> modAmt);
            carryOut = srcVal[lowIdx];
          end else begin
            result   = {DATA_W{srcVal[DATA_W-1]}};
            carryOut = srcVal[DATA_W-1];
          end
        end
      end
      SK_ROR: begin
        if (!isZero) begin
          if (modAmt == '0) begin
            carryOut = srcVal[DATA_W-1];
          end else begin
            result   = (srcVal >> modAmt) | (srcVal << highIdx);
            carryOut = srcVal[lowIdx];
          end
        end
      end
      SK_RRX: begin
        result   = {carryIn, srcVal[DATA_W-1:1]};
        carryOut = srcVal[0];
      end
      default: begin
        result   = srcVal;
        carryOut = carryIn;
      end
    endcase
  end

endmodule

// File: rtl/opshift_datapath.sv
module opshift_datapath
  import opshift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 12,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4,
  parameter int AMT_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  shiftCtrl_t         ctrl,
  input  logic               immSel,
  input  logic [FIELD_W-1:0] opField,
  input  logic [DATA_W-1:0]  rmValue,
  input  logic [DATA_W-1:0]  rsValue,
  input  logic               carryIn,
  output logic [DATA_W-1:0]  operand,
  output logic               carryOut
);

  localparam int SHAMT_W = FIELD_W - SHAMT_LSB;
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic [AMT_W-1:0]   amtReg;
  shiftKind_e         kind;
  logic [DATA_W-1:0]  srcVal;
  logic [AMT_W-1:0]   amount;
  logic [1:0]         typeBits;
  logic [SHAMT_W-1:0] encAmt;
  logic               unusedBits;

  // The register indices are resolved by the register file, not here
  assign unusedBits = ^{opField[3:0], rsValue[DATA_W-1:AMT_W]};

  // Register amount is read in the stall cycle and held for the next one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      amtReg <= '0;
    end else if (ctrl.captureAmt) begin
      amtReg <= rsValue[AMT_W-1:0];
    end
  end

  always_comb begin
    typeBits = opField[TYPE_LSB+1:TYPE_LSB];
    encAmt   = opField[FIELD_W-1:SHAMT_LSB];
    kind     = SK_LSL;
    srcVal   = rmValue;
    amount   = '0;

    if (immSel) begin
      kind   = SK_ROR;
      srcVal = DATA_W'(opField[IMM_W-1:0]);
      amount = AMT_W'({opField[IMM_W+ROT_W-1:IMM_W], 1'b0});
    end else if (opField[REG_FLAG_BIT]) begin
      kind   = shiftKind_e'({1'b0, typeBits});
      amount = ctrl.useLatched ? amtReg : rsValue[AMT_W-1:0];
    end else begin
      amount = AMT_W'(encAmt);
      case (typeBits)
        2'b00: kind = SK_LSL;
        2'b01: begin
          kind = SK_LSR;
          if (encAmt == '0) amount = FULL_AMT;
        end
        2'b10: begin
          kind = SK_ASR;
          if (encAmt == '0) amount = FULL_AMT;
        end
        default: kind = (encAmt == '0) ? SK_RRX : SK_ROR;
      endcase
    end
  end

  opshift_core #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W)
  ) u_core (
    .kind     (kind),
    .srcVal   (srcVal),
    .amount   (amount),
    .carryIn  (carryIn),
    .result   (operand),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/opshift_ctrl.sv
module opshift_ctrl
  import opshift_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic       immSel,
  input  logic       regShift,
  output shiftCtrl_t ctrl,
  output logic       stallReq
);

  typedef enum logic {ST_IDLE, ST_EXTRA} state_e;

  state_e state;
  state_e stateNext;

  always_comb begin
    stallReq        = (state == ST_IDLE) && opValid && !immSel && regShift;
    ctrl.captureAmt = stallReq;
    ctrl.useLatched = (state == ST_EXTRA);
    stateNext       = stallReq ? ST_EXTRA : ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import opshift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 12,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4,
  parameter int AMT_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               opValid,
  input  logic               immSel,
  input  logic [FIELD_W-1:0] opField,
  input  logic [DATA_W-1:0]  rmValue,
  input  logic [DATA_W-1:0]  rsValue,
  input  logic               carryIn,
  output logic [DATA_W-1:0]  operand,
  output logic               carryOut,
  output logic               stallReq
);

  shiftCtrl_t ctrl;

  opshift_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .immSel   (immSel),
    .regShift (opField[REG_FLAG_BIT]),
    .ctrl     (ctrl),
    .stallReq (stallReq)
  );

  opshift_datapath #(
    .DATA_W  (DATA_W),
    .FIELD_W (FIELD_W),
    .IMM_W   (IMM_W),
    .ROT_W   (ROT_W),
    .AMT_W   (AMT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .immSel   (immSel),
    .opField  (opField),
    .rmValue  (rmValue),
    .rsValue  (rsValue),
    .carryIn  (carryIn),
    .operand  (operand),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/opshift_chk.sv
module opshift_chk #(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               opValid,
  input logic               immSel,
  input logic [FIELD_W-1:0] opField,
  input logic [DATA_W-1:0]  rmValue,
  input logic               carryIn,
  input logic [DATA_W-1:0]  operand,
  input logic               carryOut,
  input logic               stallReq
);

  // R8
  stall_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |=> !stallReq);

  // R8
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |-> (opValid && !immSel && opField[4]));

  // R8
  stall_fresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !immSel && opField[4] && !$past(stallReq)) |-> stallReq);

  // R2
  imm_rot_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && immSel && opField[11:8] != 4'd0) |-> (carryOut == operand[DATA_W-1]));

  // R1
  imm_norot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && immSel && opField[11:8] == 4'd0)
      |-> (operand == DATA_W'(opField[7:0]) && carryOut == carryIn));

  // R3
  lsl_zero_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !immSel && opField[11:4] == 8'd0)
      |-> (operand == rmValue && carryOut == carryIn));

endmodule

bind operand_shifter opshift_chk #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_chk (.*);

// File: tb/operand_shifter_tb.sv
`timescale 1ns/1ps
module operand_shifter_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic        immSel;
  logic [11:0] opField;
  logic [31:0] rmValue;
  logic [31:0] rsValue;
  logic        carryIn;
  logic [31:0] operand;
  logic        carryOut;
  logic        stallReq;

  int checks   = 0;
  int failures = 0;
  bit reported = 1'b0;

  always #5 clk = ~clk;

  operand_shifter u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .immSel   (immSel),
    .opField  (opField),
    .rmValue  (rmValue),
    .rsValue  (rsValue),
    .carryIn  (carryIn),
    .operand  (operand),
    .carryOut (carryOut),
    .stallReq (stallReq)
  );

  // Bit-serial reference model. Kinds: 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 one-bit rotate through carry.
  // The result is {carry, value}.
  function automatic logic [32:0] refShift(input int kind, input logic [31:0] v,
                                           input int amt, input logic c);
    logic [31:0] w;
    logic        cy;
    w  = v;
    cy = c;
    if (kind == 4) return {v[0], c, v[31:1]};
    for (int i = 0; i < amt; i++) begin
      case (kind)
        0:       begin cy = w[31]; w = {w[30:0], 1'b0}; end
        1:       begin cy = w[0];  w = {1'b0, w[31:1]}; end
        2:       begin cy = w[0];  w = {w[31], w[31:1]}; end
        default: begin cy = w[0];  w = {w[0], w[31:1]}; end
      endcase
    end
    return {cy, w};
  endfunction

  task automatic checkVal(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Rotated-immediate mode, R1/R2
  task automatic runImm(input logic [3:0] rot, input logic [7:0] imm, input logic c,
                        input string tag);
    @(negedge clk);
    opValid = 1'b1; immSel = 1'b1; opField = {rot, imm}; carryIn = c;
    rmValue = $urandom; rsValue = $urandom;
    #2;
    checkVal({tag, " imm"}, {carryOut, operand},
             refShift(3, {24'd0, imm}, 2 * int'(rot), c));
    checkVal("R8 imm no stall", {32'd0, stallReq}, 33'd0);
  endtask

  // Encoded-amount shift, R3/R4/R5
  task automatic runEnc(input logic [1:0] ty, input logic [4:0] sh, input logic [31:0] rm,
                        input logic c, input string tag);
    int kind;
    int amt;
    @(negedge clk);
    opValid = 1'b1; immSel = 1'b0; opField = {sh, ty, 1'b0, 4'h3}; carryIn = c;
    rmValue = rm; rsValue = $urandom;
    kind = int'(ty);
    amt  = int'(sh);
    if (sh == 5'd0 && (ty == 2'b01 || ty == 2'b10)) amt = 32;
    if (sh == 5'd0 && ty == 2'b11) kind = 4;
    #2;
    checkVal({tag, " enc"}, {carryOut, operand}, refShift(kind, rm, amt, c));
    checkVal("R8 enc no stall", {32'd0, stallReq}, 33'd0);
  endtask

  // Register-amount shift, R6/R7/R8
  task automatic runReg(input logic [1:0] ty, input logic [7:0] amt, input logic [31:0] rm,
                        input logic c, input string tag);
    @(negedge clk);
    opValid = 1'b1; immSel = 1'b0; opField = {4'h5, 1'b0, ty, 1'b1, 4'h3}; carryIn = c;
    rsValue = {24'($urandom), amt}; rmValue = $urandom;
    #2;
    checkVal("R8 reg stall first cycle", {32'd0, stallReq}, 33'd1);
    @(negedge clk);
    rsValue = {24'($urandom), amt ^ 8'hA5};  // R6: later change must be ignored
    rmValue = rm;
    #2;
    checkVal("R8 reg no stall second cycle", {32'd0, stallReq}, 33'd0);
    checkVal({tag, " reg"}, {carryOut, operand}, refShift(int'(ty), rm, int'(amt), c));
  endtask

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; opValid = 1'b0; immSel = 1'b0; opField = '0;
    rmValue = '0; rsValue = '0; carryIn = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    checkVal("R9 stall low in reset", {32'd0, stallReq}, 33'd0);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    checkVal("R9 stall low after reset", {32'd0, stallReq}, 33'd0);
    runReg(2'b00, 8'd4, 32'h0000_00F1, 1'b0, "R9 first reg shift");

    // R1/R2 directed
    runImm(4'd0,  8'hFF, 1'b1, "R2 rot0 keeps carry");
    runImm(4'd13, 8'h40, 1'b1, "R1 4096");
    runImm(4'd8,  8'hFF, 1'b0, "R1 ror16");
    runImm(4'd1,  8'h03, 1'b0, "R2 carry from bit31");
    runImm(4'd15, 8'hFF, 1'b1, "R1 ror30");

    // R3/R4/R5 directed
    runEnc(2'b00, 5'd0,  32'hDEAD_BEEF, 1'b1, "R3 lsl0 pass");
    runEnc(2'b00, 5'd1,  32'h8000_0001, 1'b0, "R3 lsl1");
    runEnc(2'b00, 5'd31, 32'h0000_0003, 1'b0, "R3 lsl31");
    runEnc(2'b01, 5'd0,  32'h8000_0000, 1'b0, "R4 lsr32");
    runEnc(2'b10, 5'd0,  32'h8000_1234, 1'b0, "R4 asr32 neg");
    runEnc(2'b10, 5'd0,  32'h7000_1234, 1'b1, "R4 asr32 pos");
    runEnc(2'b10, 5'd4,  32'hF000_0018, 1'b0, "R4 asr4");
    runEnc(2'b11, 5'd0,  32'h0000_0001, 1'b1, "R5 rrx c1");
    runEnc(2'b11, 5'd0,  32'h0000_0002, 1'b0, "R5 rrx c0");
    runEnc(2'b11, 5'd8,  32'h1234_5680, 1'b0, "R5 ror8");

    // R6/R7 directed
    runReg(2'b01, 8'd0,   32'h1234_5678, 1'b1, "R6 amount0");
    runReg(2'b11, 8'd0,   32'h8765_4321, 1'b0, "R6 ror amount0");
    runReg(2'b01, 8'd5,   32'h0000_0030, 1'b0, "R6 lsr5");
    runReg(2'b00, 8'd32,  32'h0000_0001, 1'b0, "R7 lsl32");
    runReg(2'b00, 8'd33,  32'hFFFF_FFFF, 1'b1, "R7 lsl33");
    runReg(2'b01, 8'd32,  32'h8000_0000, 1'b0, "R7 lsr32");
    runReg(2'b01, 8'd33,  32'hFFFF_FFFF, 1'b1, "R7 lsr33");
    runReg(2'b10, 8'd200, 32'h8000_0000, 1'b0, "R7 asr200");
    runReg(2'b11, 8'd32,  32'h8000_0001, 1'b0, "R7 ror32");
    runReg(2'b11, 8'd40,  32'h0000_0080, 1'b0, "R7 ror40");
    runReg(2'b11, 8'd255, 32'h0000_0001, 1'b0, "R7 ror255");

    // Back-to-back register shifts, R8
    runReg(2'b00, 8'd3, 32'h0F0F_0F0F, 1'b0, "R8 back to back a");
    runReg(2'b01, 8'd3, 32'h0F0F_0F0F, 1'b0, "R8 back to back b");

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      int mode;
      mode = int'($urandom % 3);
      if (mode == 0) begin
        runImm(4'($urandom), 8'($urandom), 1'($urandom), "R1 R2 random");
      end else if (mode == 1) begin
        runEnc(2'($urandom), 5'($urandom), $urandom, 1'($urandom), "R3 R4 R5 random");
      end else begin
        logic [7:0] a;
        a = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 34);
        runReg(2'($urandom), a, $urandom, 1'($urandom), "R6 R7 random");
      end
    end

    @(negedge clk);
    opValid = 1'b0;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

endmodule